// File: doc/BRIEF.md
# Random Single-Input-Change Pattern Generator

This block is a built-in self-test stimulus source for at-speed delay testing. It holds an n-bit test vector and, on each advance request, inverts exactly one bit of it. The bit is picked pseudo-randomly and uniformly across the n positions, so that every pair of consecutive vectors forms a two-pattern test whose only transition is at a single input of the circuit under test.

A maximal-length Fibonacci LFSR is the source of randomness. On each advance the LFSR moves forward by a whole fraction's worth of shifts, so every draw uses bits the previous draw never saw. The top bits of the new state are read as a binary fraction in [0,1). That fraction is multiplied by n and truncated to give the bit index, which needs no modulo step. Reset loads the LFSR seed and the starting vector, and the same seed always gives the same sequence.

Top module: `sic_pattern_gen`

## Requirements
- R1: While `rst` is high at a rising edge, `vec_o` takes `init_vec_i`, the LFSR takes `seed_i`, and `valid_o` goes to 0.
- R2: A `seed_i` of zero loaded at reset is replaced by the value 1, so the LFSR never holds the all-zero state.
- R3: When `adv_i` is high at a rising edge, `vec_o` after that edge differs from `vec_o` before it in exactly one bit, and `valid_o` is 1 for the following cycle.
- R4: When `adv_i` is low at a rising edge, `vec_o` and the LFSR state keep their values and `valid_o` is 0 for the following cycle.
- R5: The LFSR has 32 bits (default `LFSR_W`). One shift moves the state left by one place and puts into bit 0 the XOR of state bits 31, 21, 1 and 0. Each advance applies 16 (`FRAC_W`) shifts.
- R6: The fraction Y is the top 16 bits of the LFSR state after the shifts of the current advance. The index is i = floor(Y·N / 2^16), which always lies in 0..N−1.
- R7: Index i inverts vector bit N−1−i. Index 0 therefore addresses the most significant bit, and index N−1 the least significant bit.
- R8: Over 24000 consecutive advances with N = 24, each of the 24 positions toggles within ±20 % of 1000 times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; loads seed and start vector |
| seed_i | input | LFSR_W | LFSR seed taken during reset |
| init_vec_i | input | N | Start vector taken during reset |
| adv_i | input | 1 | Advance: flip one random bit this cycle |
| vec_o | output | N | Current test vector (bit N−1 is the first input) |
| valid_o | output | 1 | High for one cycle after each advance |

## Verification
The property hardest to reach from the ports is uniformity of the chosen position. It only shows over thousands of draws, and it also depends on the LFSR holding its state through idle cycles. The bench therefore runs one long unbroken stretch of advances and bins each flipped position, which it recovers from the XOR of consecutive vectors. Around that stretch it interleaves random idle cycles, a mid-run reset and a zero seed. A behavioural reference draw is compared with the output on every clock, so a lost or repeated LFSR step shows up at once as a wrong bit.

// File: rtl/sic_pkg.sv
package sic_pkg;

  // Feedback tap mask for a maximal-length Fibonacci LFSR of the given width.
  // Bit (t-1) is set for each tap t of the feedback polynomial.
  function automatic logic [63:0] tap_mask(input int width);
    logic [63:0] m;
    m = '0;
    case (width)
      16: begin m[15] = 1'b1; m[14] = 1'b1; m[12] = 1'b1; m[3]  = 1'b1; end
      24: begin m[23] = 1'b1; m[22] = 1'b1; m[21] = 1'b1; m[16] = 1'b1; end
      48: begin m[47] = 1'b1; m[46] = 1'b1; m[20] = 1'b1; m[19] = 1'b1; end
      64: begin m[63] = 1'b1; m[62] = 1'b1; m[60] = 1'b1; m[59] = 1'b1; end
      default: begin m[31] = 1'b1; m[21] = 1'b1; m[1] = 1'b1; m[0] = 1'b1; end
    endcase
    return m;
  endfunction

  // Ceiling log2 with a floor of one bit.
  function automatic int idx_bits(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/sic_lfsr.sv
module sic_lfsr #(
  parameter int W     = 32,
  parameter int STEPS = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] seed_i,
  input  logic         adv_i,
  output logic [W-1:0] state_o,
  output logic [W-1:0] next_o
);
  localparam logic [W-1:0] TAPS     = W'(sic_pkg::tap_mask(W));
  localparam logic [W-1:0] ZERO_SUB = W'(1);

  logic [W-1:0] state_q;
  logic [W-1:0] chain [STEPS+1];

  assign chain[0] = state_q;

  // Unrolled multi-shift so each advance consumes STEPS fresh bits.
  for (genvar s = 0; s < STEPS; s++) begin : g_shift
    logic fb;
    assign fb           = ^(chain[s] & TAPS);
    assign chain[s+1]   = {chain[s][W-2:0], fb};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= (seed_i == '0) ? ZERO_SUB : seed_i;
    end else if (adv_i) begin
      state_q <= chain[STEPS];
    end
  end

  assign state_o = state_q;
  assign next_o  = chain[STEPS];
endmodule

// File: rtl/sic_index_scale.sv
module sic_index_scale #(
  parameter int N      = 24,
  parameter int FRAC_W = 16,
  localparam int IDX_W = sic_pkg::idx_bits(N),
  localparam int PROD_W = FRAC_W + IDX_W
) (
  input  logic [FRAC_W-1:0] frac_i,
  output logic [IDX_W-1:0]  idx_o
);
  localparam logic [PROD_W-1:0] N_EXT = PROD_W'(N);

  logic [PROD_W-1:0] prod;

  // frac < 2^FRAC_W and N <= 2^IDX_W, so the product never overflows PROD_W.
  assign prod  = PROD_W'(frac_i) * N_EXT;
  assign idx_o = IDX_W'(prod >> FRAC_W);
endmodule

// File: rtl/sic_vec_reg.sv
module sic_vec_reg #(
  parameter int N      = 24,
  localparam int IDX_W = sic_pkg::idx_bits(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     init_i,
  input  logic             adv_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [N-1:0]     vec_o,
  output logic             valid_o
);
  logic [N-1:0] vec_q;
  logic         valid_q;
  logic [N-1:0] flip_mask;

  // Index 0 addresses the MSB (first circuit input).
  for (genvar j = 0; j < N; j++) begin : g_mask
    assign flip_mask[j] = (idx_i == IDX_W'(N - 1 - j));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q   <= init_i;
      valid_q <= 1'b0;
    end else begin
      valid_q <= adv_i;
      if (adv_i) begin
        vec_q <= vec_q ^ flip_mask;
      end
    end
  end

  assign vec_o   = vec_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/sic_pattern_gen.sv
module sic_pattern_gen #(
  parameter int N      = 24,
  parameter int LFSR_W = 32,
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LFSR_W-1:0] seed_i,
  input  logic [N-1:0]      init_vec_i,
  input  logic              adv_i,
  output logic [N-1:0]      vec_o,
  output logic              valid_o
);
  localparam int IDX_W = sic_pkg::idx_bits(N);

  logic [LFSR_W-1:0] lfsr_state;
  logic [LFSR_W-1:0] lfsr_next;
  logic [FRAC_W-1:0] frac;
  logic [IDX_W-1:0]  flip_idx;

  sic_lfsr #(.W(LFSR_W), .STEPS(FRAC_W)) u_lfsr (
    .clk     (clk),
    .rst     (rst),
    .seed_i  (seed_i),
    .adv_i   (adv_i),
    .state_o (lfsr_state),
    .next_o  (lfsr_next)
  );

  assign frac = lfsr_next[LFSR_W-1 -: FRAC_W];

  sic_index_scale #(.N(N), .FRAC_W(FRAC_W)) u_scale (
    .frac_i (frac),
    .idx_o  (flip_idx)
  );

  sic_vec_reg #(.N(N)) u_vec (
    .clk     (clk),
    .rst     (rst),
    .init_i  (init_vec_i),
    .adv_i   (adv_i),
    .idx_i   (flip_idx),
    .vec_o   (vec_o),
    .valid_o (valid_o)
  );
endmodule

// File: rtl/sic_pattern_gen_chk.sv
module sic_pattern_gen_chk #(
  parameter int N      = 24,
  parameter int LFSR_W = 32,
  parameter int IDX_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              adv_i,
  input logic [N-1:0]      vec_o,
  input logic              valid_o,
  input logic [LFSR_W-1:0] lfsr_q,
  input logic [IDX_W-1:0]  flip_idx
);
  // R3
  one_bit_flip_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> ($countones(vec_o ^ $past(vec_o)) == 1));

  // R3
  valid_follows_adv_chk: assert property (@(posedge clk) disable iff (rst)
    adv_i |=> valid_o);

  // R4
  idle_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !adv_i |=> !valid_o);

  // R4
  idle_vec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !adv_i |=> $stable(vec_o));

  // R4
  idle_lfsr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !adv_i |=> $stable(lfsr_q));

  // R5
  lfsr_moves_chk: assert property (@(posedge clk) disable iff (rst)
    adv_i |=> (lfsr_q != $past(lfsr_q)));

  // R2
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    lfsr_q != '0);

  // R6
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    adv_i |-> (int'(flip_idx) < N));
endmodule

bind sic_pattern_gen sic_pattern_gen_chk #(
  .N(N), .LFSR_W(LFSR_W), .IDX_W(IDX_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .adv_i    (adv_i),
  .vec_o    (vec_o),
  .valid_o  (valid_o),
  .lfsr_q   (lfsr_state),
  .flip_idx (flip_idx)
);

// File: tb/sic_pattern_gen_tb.sv
module sic_pattern_gen_tb;
  localparam int N      = 24;
  localparam int LW     = 32;
  localparam int FW     = 16;
  localparam int HSTEPS = 24000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [LW-1:0] seed_i = '0;
  logic [N-1:0]  init_vec_i = '0;
  logic          adv_i = 1'b0;
  logic [N-1:0]  vec_o;
  logic          valid_o;

  always #5 clk = ~clk;

  sic_pattern_gen #(.N(N), .LFSR_W(LW), .FRAC_W(FW)) u_dut (
    .clk(clk), .rst(rst), .seed_i(seed_i), .init_vec_i(init_vec_i),
    .adv_i(adv_i), .vec_o(vec_o), .valid_o(valid_o)
  );

  int tests = 0;
  int fails = 0;

  // Reference state
  bit [31:0]    m_s;
  bit [N-1:0]   m_v;
  bit           m_valid;
  bit [N-1:0]   prev_vec;
  bit           hist_on = 1'b0;
  int           hist [N];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R5: 16 shifts, left, feedback = s[31]^s[21]^s[1]^s[0]
  function automatic bit [31:0] ref_draw(input bit [31:0] s);
    bit [31:0] t = s;
    for (int k = 0; k < FW; k++) begin
      bit f = t[31] ^ t[21] ^ t[1] ^ t[0];
      t = {t[30:0], f};
    end
    return t;
  endfunction

  task automatic do_reset(input bit [31:0] seed, input bit [N-1:0] init);
    rst = 1'b1; adv_i = 1'b0; seed_i = seed; init_vec_i = init;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_s = (seed == 0) ? 32'd1 : seed; // R2
    m_v = init;
    m_valid = 1'b0;
    // R1
    chk(vec_o == init, "R1 reset vector", 64'(vec_o), 64'(init));
    chk(valid_o == 1'b0, "R1 reset valid", 64'(valid_o), 64'd0);
    prev_vec = vec_o;
  endtask

  task automatic tick(input bit a);
    int idx;
    adv_i = a;
    @(negedge clk);
    if (a) begin
      m_s = ref_draw(m_s);
      idx = (int'(m_s[31:16]) * N) / 65536;            // R6
      m_v[N-1-idx] = ~m_v[N-1-idx];                    // R7
    end
    m_valid = a;
    if (a) chk(vec_o == m_v, "R5 R6 R7 vector", 64'(vec_o), 64'(m_v));
    else   chk(vec_o == m_v, "R4 hold vector", 64'(vec_o), 64'(m_v));
    chk(valid_o == m_valid, a ? "R3 valid" : "R4 valid", 64'(valid_o), 64'(m_valid));
    if (valid_o) begin
      chk($countones(vec_o ^ prev_vec) == 1, "R3 single flip",
          64'($countones(vec_o ^ prev_vec)), 64'd1);
      if (hist_on) begin
        for (int p = 0; p < N; p++)
          if (vec_o[p] != prev_vec[p]) hist[N-1-p]++;
      end
    end
    prev_vec = vec_o;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) hist[i] = 0;
    @(negedge clk);
    do_reset(32'hACE1_1234, 24'hA5C3F0);

    // Mixed advance/idle pattern
    for (int c = 0; c < 2000; c++) tick(bit'($urandom_range(0, 1)));

    // Long idle then resume: LFSR must not have moved (R4)
    for (int c = 0; c < 40; c++) tick(1'b0);
    for (int c = 0; c < 20; c++) tick(1'b1);

    // Mid-run reset with a different seed and start vector (R1)
    do_reset(32'h1357_9BDF, 24'h000000);
    for (int c = 0; c < 500; c++) tick(c % 3 != 0);

    // Zero seed must behave as seed 1 (R2)
    do_reset(32'h0, 24'hFFFFFF);
    for (int c = 0; c < 300; c++) tick(1'b1);
    chk(vec_o == m_v, "R2 zero seed run", 64'(vec_o), 64'(m_v));

    // Histogram over an unbroken run (R8)
    do_reset(32'hDEAD_BEEF, 24'h5A5A5A);
    hist_on = 1'b1;
    for (int c = 0; c < HSTEPS; c++) tick(1'b1);
    hist_on = 1'b0;
    for (int i = 0; i < N; i++)
      chk(hist[i] >= 800 && hist[i] <= 1200, $sformatf("R8 position %0d count", i),
          64'(hist[i]), 64'd1000);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule